// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing core of an on-chip debug unit. Three comparator channels each deliver a single-cycle match pulse. The block settles which of several same-cycle pulses counts, and then steps a small state machine. The machine has a disarmed state, three intermediate states that software may chain in any order, and a final state. Reaching the final state marks the trigger point at which trace capture begins. A session then ends with a return to the disarmed state.

Software arms the sequencer. For each intermediate state and each channel, a 3-bit control code gives the state that a match on that channel leads to. Software may also force the trigger with a strobe. Each channel can also request an immediate breakpoint, and such a match ends the session through the final state. In range mode, channels 0 and 1 act as one range comparator that reports on channel 0.

The state names used below are DISARMED (code 000), ONE (001), TWO (010), THREE (011) and FINAL (100). The named transitions are:
- arm: DISARMED to ONE.
- step: ONE, TWO or THREE to any of ONE, TWO or THREE.
- trigger: ONE, TWO or THREE to FINAL, taken by a match, a breakpoint or the strobe.
- complete: FINAL to DISARMED.
- abort: any state to DISARMED.

Top module: `dbg_seq_core`

## Requirements
- R1: After reset, `state_o` is 000 and `armed_o`, `trace_start_o` and `brk_req_o` are 0.
- R2: A pulse on `arm_set_i` in DISARMED, without `arm_clr_i`, gives `state_o` = 001 and `armed_o` = 1 after the next clock edge.
- R3: A pulse on `arm_clr_i` moves the block to DISARMED with `armed_o` = 0 after the next edge, from any state and over any match or strobe in that cycle.
- R4: The field `next_ctl_i[(s-1)*9 + c*3 +: 3]` holds the code for a channel-c match in intermediate state s. Code 1, 2 or 3 moves to that state, code 4 moves to FINAL, and codes 0 and 5 to 7 leave the state unchanged.
- R5: When several channel matches arrive together and none of them leads to FINAL, only the lowest-numbered channel's code is acted on.
- R6: A match that leads to FINAL beats every other same-cycle match, whatever the channel numbers. A match leads to FINAL when its code is 4 or its breakpoint enable is set.
- R7: With `range_mode_i` high, a match on channel 1 is disregarded. A channel-2 match in the same cycle as a channel-0 match is suppressed, even when its code is 4. A channel-2 match on its own is still acted on.
- R8: FINAL lasts exactly one cycle and is followed by DISARMED. `armed_o` falls on the cycle after `state_o` first shows 100.
- R9: A pulse on `sw_trig_i` while armed in an intermediate state moves the block to FINAL and takes precedence over matches. While the block is disarmed, the pulse has no effect.
- R10: `trace_start_o` is a one-cycle pulse in the first cycle that `state_o` shows 100. It appears only if `trace_en_i` was high in the cycle of the transition.
- R11: A match on a channel whose `brk_en_i` bit is set, in an intermediate state, raises `brk_req_o` for one cycle. That cycle coincides with `state_o` = 100, whatever the channel's code.
- R12: Match pulses in DISARMED do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_set_i | input | 1 | Pulse that arms the sequencer |
| arm_clr_i | input | 1 | Pulse that disarms the sequencer |
| sw_trig_i | input | 1 | Software trigger strobe |
| trace_en_i | input | 1 | Tracing enabled |
| range_mode_i | input | 1 | Channels 0 and 1 form one range comparator |
| brk_en_i | input | 3 | Per-channel breakpoint enable |
| match_i | input | 3 | Per-channel match pulse |
| next_ctl_i | input | 27 | Next-state codes, 3 bits per channel per intermediate state |
| state_o | output | 3 | Current state flags |
| armed_o | output | 1 | Armed indication |
| trace_start_o | output | 1 | Trace capture start pulse |
| brk_req_o | output | 1 | Breakpoint request pulse |

## Verification
Two things can land in one cycle: channel matches that compete with each other, and a match that competes with the software strobe, a disarm or a breakpoint. The bench provokes each case by raising several `match_i` bits together, or by raising a match together with `sw_trig_i`, `arm_clr_i` or a breakpoint-enabled channel. The control codes are chosen so that every candidate winner leads to a different state. The winner can then be read from `state_o` on the next cycle, and `trace_start_o` and `brk_req_o` are compared in that same cycle.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam int NUM_CH   = 3;
    localparam int NUM_MID  = 3;
    localparam int CODE_W   = 3;
    localparam int STATE_W  = 3;
    localparam int CTL_W    = NUM_CH * NUM_MID * CODE_W;
    localparam logic [CODE_W-1:0] CODE_TO_FINAL = 3'd4;

    typedef enum logic [STATE_W-1:0] {
        ST_DISARMED = 3'd0,
        ST_ONE      = 3'd1,
        ST_TWO      = 3'd2,
        ST_THREE    = 3'd3,
        ST_FINAL    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dbg_ctl_select.sv
// Picks the per-channel next-state codes that belong to the current intermediate state.
module dbg_ctl_select
    import dbg_seq_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int N_MID = NUM_MID,
    parameter int CW    = CODE_W,
    parameter int SW    = STATE_W
) (
    input  logic [SW-1:0]            state_i,
    input  logic [N_CH*N_MID*CW-1:0] ctl_i,
    output logic [N_CH*CW-1:0]       codes_o
);

    localparam int ROW_W = N_CH * CW;

    always_comb begin
        codes_o = '0;
        for (int s = 1; s <= N_MID; s++) begin
            if (state_i == SW'(s)) begin
                codes_o = ctl_i[(s-1)*ROW_W +: ROW_W];
            end
        end
    end

endmodule

// File: rtl/dbg_match_arbiter.sv
// Masks matches (activity, range mode) and picks one winner by priority.
module dbg_match_arbiter
    import dbg_seq_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int CW   = CODE_W
) (
    input  logic                 active_i,
    input  logic                 range_mode_i,
    input  logic [N_CH-1:0]      match_i,
    input  logic [N_CH-1:0]      brk_en_i,
    input  logic [N_CH*CW-1:0]   codes_i,
    output logic                 win_valid_o,
    output logic                 win_final_o,
    output logic [CW-1:0]        win_code_o,
    output logic                 brk_hit_o
);

    logic [N_CH-1:0] m_eff;
    logic [N_CH-1:0] to_final;

    always_comb begin
        m_eff = active_i ? match_i : '0;
        if (range_mode_i) begin
            m_eff[1] = 1'b0;
            if (m_eff[0]) begin
                m_eff[2] = 1'b0;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_lead
            assign to_final[g] = m_eff[g] &
                                 ((codes_i[g*CW +: CW] == CODE_TO_FINAL) | brk_en_i[g]);
        end
    endgenerate

    always_comb begin
        win_valid_o = |m_eff;
        win_final_o = |to_final;
        win_code_o  = '0;
        if (|to_final) begin
            win_code_o = CODE_TO_FINAL;
        end else begin
            for (int i = N_CH - 1; i >= 0; i--) begin
                if (m_eff[i]) begin
                    win_code_o = codes_i[i*CW +: CW];
                end
            end
        end
    end

    assign brk_hit_o = |(m_eff & brk_en_i);

endmodule

// File: rtl/dbg_seq_fsm.sv
// State register, armed register and registered trace / breakpoint outputs.
module dbg_seq_fsm
    import dbg_seq_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int SW = STATE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm_set_i,
    input  logic           arm_clr_i,
    input  logic           sw_trig_i,
    input  logic           trace_en_i,
    input  logic           win_valid_i,
    input  logic           win_final_i,
    input  logic [CW-1:0]  win_code_i,
    input  logic           brk_hit_i,
    output logic [SW-1:0]  state_o,
    output logic           in_mid_o,
    output logic           armed_o,
    output logic           trace_start_o,
    output logic           brk_req_o
);

    seq_state_e state_q, state_d;
    logic       armed_q, armed_d;
    logic       trace_q, brk_q;

    assign in_mid_o = (state_q == ST_ONE) || (state_q == ST_TWO) || (state_q == ST_THREE);

    always_comb begin
        state_d = state_q;
        armed_d = armed_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (arm_set_i) begin
                    state_d = ST_ONE;
                    armed_d = 1'b1;
                end
            end
            ST_ONE, ST_TWO, ST_THREE: begin
                if (sw_trig_i && armed_q) begin
                    state_d = ST_FINAL;
                end else if (win_valid_i) begin
                    if (win_final_i) begin
                        state_d = ST_FINAL;
                    end else if (win_code_i >= CW'(1) && win_code_i <= CW'(3)) begin
                        state_d = seq_state_e'(win_code_i);
                    end
                end
            end
            ST_FINAL: begin
                state_d = ST_DISARMED;
                armed_d = 1'b0;
            end
            default: begin
                state_d = ST_DISARMED;
                armed_d = 1'b0;
            end
        endcase
        if (arm_clr_i) begin
            state_d = ST_DISARMED;
            armed_d = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DISARMED;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trace_q <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            trace_q <= trace_en_i && (state_d == ST_FINAL) && (state_q != ST_FINAL);
            brk_q   <= brk_hit_i && (state_d == ST_FINAL);
        end
    end

    assign state_o       = state_q;
    assign armed_o       = armed_q;
    assign trace_start_o = trace_q;
    assign brk_req_o     = brk_q;

endmodule

// File: rtl/dbg_seq_core.sv
module dbg_seq_core
    import dbg_seq_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int N_MID = NUM_MID,
    parameter int CW    = CODE_W,
    parameter int SW    = STATE_W,
    localparam int CTLW = N_CH * N_MID * CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_set_i,
    input  logic            arm_clr_i,
    input  logic            sw_trig_i,
    input  logic            trace_en_i,
    input  logic            range_mode_i,
    input  logic [N_CH-1:0] brk_en_i,
    input  logic [N_CH-1:0] match_i,
    input  logic [CTLW-1:0] next_ctl_i,
    output logic [SW-1:0]   state_o,
    output logic            armed_o,
    output logic            trace_start_o,
    output logic            brk_req_o
);

    logic [N_CH*CW-1:0] codes;
    logic               in_mid;
    logic               win_valid, win_final, brk_hit;
    logic [CW-1:0]      win_code;

    dbg_ctl_select #(.N_CH(N_CH), .N_MID(N_MID), .CW(CW), .SW(SW)) u_sel (
        .state_i (state_o),
        .ctl_i   (next_ctl_i),
        .codes_o (codes)
    );

    dbg_match_arbiter #(.N_CH(N_CH), .CW(CW)) u_arb (
        .active_i     (in_mid),
        .range_mode_i (range_mode_i),
        .match_i      (match_i),
        .brk_en_i     (brk_en_i),
        .codes_i      (codes),
        .win_valid_o  (win_valid),
        .win_final_o  (win_final),
        .win_code_o   (win_code),
        .brk_hit_o    (brk_hit)
    );

    dbg_seq_fsm #(.CW(CW), .SW(SW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_set_i     (arm_set_i),
        .arm_clr_i     (arm_clr_i),
        .sw_trig_i     (sw_trig_i),
        .trace_en_i    (trace_en_i),
        .win_valid_i   (win_valid),
        .win_final_i   (win_final),
        .win_code_i    (win_code),
        .brk_hit_i     (brk_hit),
        .state_o       (state_o),
        .in_mid_o      (in_mid),
        .armed_o       (armed_o),
        .trace_start_o (trace_start_o),
        .brk_req_o     (brk_req_o)
    );

endmodule

// File: rtl/dbg_seq_checker.sv
module dbg_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_set_i,
    input logic       arm_clr_i,
    input logic [2:0] state_o,
    input logic       armed_o,
    input logic       trace_start_o,
    input logic       brk_req_o
);

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    assert_arm_enters_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && arm_set_i && !arm_clr_i) |=> (state_o == 3'd1 && armed_o));

    assert_clear_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr_i |=> (state_o == 3'd0 && !armed_o));

    assert_final_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd0 && !armed_o));

    assert_trace_in_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trace_start_o |-> (state_o == 3'd4));

    assert_brk_in_final_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |-> (state_o == 3'd4));

    assert_disarmed_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !arm_set_i) |=> (state_o == 3'd0));

endmodule

bind dbg_seq_core dbg_seq_checker u_dbg_seq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_set_i     (arm_set_i),
    .arm_clr_i     (arm_clr_i),
    .state_o       (state_o),
    .armed_o       (armed_o),
    .trace_start_o (trace_start_o),
    .brk_req_o     (brk_req_o)
);

// File: tb/dbg_seq_core_bench.sv
module dbg_seq_core_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_set = 1'b0, arm_clr = 1'b0, sw_trig = 1'b0;
    logic        trace_en = 1'b0, range_mode = 1'b0;
    logic [2:0]  brk_en = '0, match = '0;
    logic [26:0] next_ctl = '0;
    logic [2:0]  state;
    logic        armed, trace_start, brk_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic       arm;
        logic       tr;
        logic       bk;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    dbg_seq_core u_dbg_seq_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_set_i     (arm_set),
        .arm_clr_i     (arm_clr),
        .sw_trig_i     (sw_trig),
        .trace_en_i    (trace_en),
        .range_mode_i  (range_mode),
        .brk_en_i      (brk_en),
        .match_i       (match),
        .next_ctl_i    (next_ctl),
        .state_o       (state),
        .armed_o       (armed),
        .trace_start_o (trace_start),
        .brk_req_o     (brk_req)
    );

    task automatic check(string tag, logic [2:0] st, logic a, logic t, logic b);
        n_checks++;
        if (state !== st || armed !== a || trace_start !== t || brk_req !== b) begin
            n_fails++;
            $display("FAIL %s: got state=%0d armed=%0b trace=%0b brk=%0b, expected state=%0d armed=%0b trace=%0b brk=%0b",
                     tag, state, armed, trace_start, brk_req, st, a, t, b);
        end
    endtask

    // Monitor: compares each cycle's result with the queued expectation
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.tag, e.st, e.arm, e.tr, e.bk);
            end
        end
    end

    function automatic void set_code(int s, int ch, logic [2:0] code);
        next_ctl[(s-1)*9 + ch*3 +: 3] = code;
    endfunction

    // Driver: one cycle of stimulus, with the outputs expected after the edge
    task automatic step(logic as, logic ac, logic tg, logic [2:0] m,
                        logic [2:0] st, logic a, logic t, logic b, string tag);
        exp_t e;
        @(negedge clk);
        arm_set = as; arm_clr = ac; sw_trig = tg; match = m;
        e.st = st; e.arm = a; e.tr = t; e.bk = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 3'd0, 1'b0, 1'b0, 1'b0);

        trace_en = 1'b1;
        set_code(1, 0, 3'd2); set_code(1, 1, 3'd3); set_code(1, 2, 3'd4);
        set_code(2, 0, 3'd1); set_code(2, 1, 3'd4); set_code(2, 2, 3'd3);
        set_code(3, 0, 3'd0); set_code(3, 1, 3'd1); set_code(3, 2, 3'd2);

        step(0, 0, 0, 3'b111, 3'd0, 0, 0, 0, "R12 matches while disarmed");
        step(0, 0, 1, 3'b000, 3'd0, 0, 0, 0, "R9 strobe ignored while disarmed");
        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 arm");
        step(0, 0, 0, 3'b011, 3'd2, 1, 0, 0, "R5 ch0 beats ch1");
        step(0, 0, 0, 3'b101, 3'd1, 1, 0, 0, "R5 ch0 beats ch2");
        step(0, 0, 0, 3'b101, 3'd4, 1, 1, 0, "R6 final match beats ch0, R10 trace");
        step(0, 0, 0, 3'b000, 3'd0, 0, 0, 0, "R8 complete and disarm");
        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 re-arm");
        step(0, 0, 0, 3'b010, 3'd3, 1, 0, 0, "R4 code 3");
        step(0, 0, 0, 3'b001, 3'd3, 1, 0, 0, "R4 code 0 stays");
        step(0, 0, 0, 3'b100, 3'd2, 1, 0, 0, "R4 code 2");
        step(0, 0, 0, 3'b011, 3'd4, 1, 1, 0, "R6 ch1 final beats ch0");
        step(0, 0, 0, 3'b000, 3'd0, 0, 0, 0, "R8 complete");

        @(negedge clk); trace_en = 1'b0;
        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 arm");
        step(0, 0, 1, 3'b001, 3'd4, 1, 0, 0, "R9 strobe beats match, R10 no trace");
        step(0, 0, 0, 3'b000, 3'd0, 0, 0, 0, "R8 complete");

        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 arm");
        step(0, 0, 0, 3'b001, 3'd2, 1, 0, 0, "R4 code 2");
        step(0, 1, 1, 3'b010, 3'd0, 0, 0, 0, "R3 clear beats final match and strobe");
        step(0, 0, 0, 3'b000, 3'd0, 0, 0, 0, "R3 stays disarmed");

        @(negedge clk); range_mode = 1'b1;
        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 arm");
        step(0, 0, 0, 3'b010, 3'd1, 1, 0, 0, "R7 ch1 disregarded");
        step(0, 0, 0, 3'b101, 3'd2, 1, 0, 0, "R7 ch2 final suppressed by ch0");
        step(0, 0, 0, 3'b100, 3'd3, 1, 0, 0, "R7 ch2 alone acted on");
        @(negedge clk); range_mode = 1'b0; brk_en = 3'b010;
        step(0, 0, 0, 3'b010, 3'd4, 1, 0, 1, "R11 breakpoint ends session");
        step(0, 0, 0, 3'b000, 3'd0, 0, 0, 0, "R8 disarm after breakpoint");

        @(negedge clk); trace_en = 1'b1;
        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 arm");
        step(0, 0, 0, 3'b011, 3'd4, 1, 1, 1, "R11 R6 breakpoint ch1 beats ch0");
        step(0, 0, 0, 3'b000, 3'd0, 0, 0, 0, "R8 complete");

        @(negedge clk); brk_en = 3'b000; set_code(1, 2, 3'd5);
        step(1, 0, 0, 3'b000, 3'd1, 1, 0, 0, "R2 arm");
        step(0, 0, 0, 3'b100, 3'd1, 1, 0, 0, "R4 code 5 stays");
        step(0, 1, 0, 3'b000, 3'd0, 0, 0, 0, "R3 clear from ONE");

        @(negedge clk);
        arm_set = 1'b0; arm_clr = 1'b0; sw_trig = 1'b0; match = '0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule